// File: doc/BRIEF.md
# Recursive Resonator Sine Tone Generator

The block synthesises a sinusoid one sample at a time from a two-pole recursive resonator. Each accepted sample strobe produces a new 16-bit signed sample by multiplying the previous sample by a Q2.14 coefficient, subtracting the sample before that, and saturating the result. The coefficient holds 2·cos(ω) and so sets the pitch. The starting value loaded into the resonator sets the amplitude. The block runs in three modes, each with its own update rate: a plain tone at an 8 kHz strobe, a ringing source at a 1 kHz strobe, and frequency-shift keying at a 24 kHz strobe.

In keying mode two parameter sets, *mark* and *space*, are programmed once. After that the host only writes data bits. A written bit that differs from the bit in force restarts the resonator from the other set's amplitude at the next accepted strobe. A written bit that equals the bit in force changes nothing. The mode and the rate are captured when the generator is enabled. While the generator is disabled the output is forced to zero.

The controller has four states. `ST_OFF` is idle with a zero output. `ST_TONE` runs the tone set at the 8 kHz or 1 kHz rate. `ST_MARK` and `ST_SPACE` run one of the two keying sets at 24 kHz. The transitions are:
- *start*: `ST_OFF` to `ST_TONE`, `ST_MARK` or `ST_SPACE` when `gen_en` rises.
- *stop*: any running state to `ST_OFF` when `gen_en` falls.
- *swap*: `ST_MARK` to `ST_SPACE` or back, on an accepted strobe when the requested bit differs from the set in force.
- *step*: a running state back to itself on an accepted strobe.

Top module: `reso_tone_gen`

## Requirements
- R1: After reset `smp_out` is 0 and `smp_valid` is 0.
- R2: Configuration words are written through `cfg_we`/`cfg_addr`/`cfg_wdata` at these addresses:
  - 0: control word. Bit 0 turns keying on. Bit 1 selects the 1 kHz ringing rate.
  - 1 and 2: tone coefficient and tone amplitude.
  - 3 and 4: mark coefficient and mark amplitude.
  - 5 and 6: space coefficient and space amplitude.
- R3: On each accepted strobe the new sample is sat16((coef·y1) >>> 14 − y2). After the step, y2 takes the old y1 and y1 takes the new sample. The new sample appears on `smp_out` with `smp_valid` high in the cycle after the strobe.
- R4: Results above 32767 are clamped to 32767, and results below −32768 are clamped to −32768.
- R5: On start, y1 is loaded with the selected amplitude and y2 with 0. The first sample is therefore sat16((coef·amp) >>> 14).
- R6: One cycle after `gen_en` falls, `smp_out` is 0 and `smp_valid` is 0. While the generator is disabled, strobes produce no samples.
- R7: In tone mode with bit 1 clear, only `tick_8k` is accepted. `tick_24k` and `tick_1k` are ignored.
- R8: With bit 1 set and bit 0 clear, only `tick_1k` is accepted.
- R9: Keying runs only when control bit 0 and `gen_en` are both set. It accepts only `tick_24k`. It starts in mark if the last written data bit is 1 and in space if it is 0; the data bit is 1 after reset.
- R10: A data bit written with `fsk_we` that differs from the set in force takes effect at the next accepted strobe. At that strobe y1 is reloaded with the new set's amplitude, y2 is reloaded with 0, and one step is taken with the new set's coefficient.
- R11: A written data bit equal to the set in force leaves the sample sequence unchanged.
- R12: Writes to the control word while the generator runs do not change its mode or rate until the next start.
- R13: Between accepted strobes `smp_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word address |
| cfg_wdata | input | 16 | Configuration write data |
| tick_8k | input | 1 | One-cycle strobe at the tone rate |
| tick_24k | input | 1 | One-cycle strobe at the keying rate |
| tick_1k | input | 1 | One-cycle strobe at the ringing rate |
| gen_en | input | 1 | Generator enable |
| fsk_we | input | 1 | Data bit write strobe |
| fsk_bit | input | 1 | Data bit: 1 mark, 0 space |
| smp_out | output | 16 | Signed output sample |
| smp_valid | output | 1 | High for one cycle when a new sample is issued |

## Verification
The bench drives strobes of the wrong rate in every mode. A design that decoded the rate wrongly would emit samples that no reference model expects, or would step twice as often. The bench drives both coefficient extremes with a large amplitude. A design that wrapped instead of clamping would flip sign on the first sample. For keying, the bench writes the same bit twice and a differing bit once. A design that reloaded on every write would restart the sinusoid when it should not, and one that ignored the difference would never change pitch. The bench also rewrites the control word mid-run, and checks that disabling zeroes the output within one cycle.

// File: rtl/tone_pkg.sv
package tone_pkg;

    typedef enum logic [1:0] {
        RATE_8K  = 2'd0,
        RATE_24K = 2'd1,
        RATE_1K  = 2'd2
    } rate_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_TONE  = 2'd1,
        ST_MARK  = 2'd2,
        ST_SPACE = 2'd3
    } gen_st_e;

    // configuration word addresses
    localparam int REG_CTRL       = 0;
    localparam int REG_TONE_COEF  = 1;
    localparam int REG_TONE_AMP   = 2;
    localparam int REG_MARK_COEF  = 3;
    localparam int REG_MARK_AMP   = 4;
    localparam int REG_SPACE_COEF = 5;
    localparam int REG_SPACE_AMP  = 6;
    localparam int REG_COUNT      = 7;

    // control word bits
    localparam int CTRL_KEY_BIT  = 0;
    localparam int CTRL_RING_BIT = 1;

endpackage

// File: rtl/tone_cfg_regs.sv
module tone_cfg_regs #(
    parameter int W    = 16,
    parameter int AW   = 3,
    parameter int NREG = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [AW-1:0]            addr_i,
    input  logic [W-1:0]             data_i,
    output logic [NREG-1:0][W-1:0]   regs_o
);

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_word
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    regs_o[g] <= '0;
                end else if (we_i && (addr_i == AW'(g))) begin
                    regs_o[g] <= data_i;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/tone_rate_sel.sv
module tone_rate_sel
    import tone_pkg::*;
(
    input  rate_e rate_i,
    input  logic  t8k_i,
    input  logic  t24k_i,
    input  logic  t1k_i,
    output logic  tick_o
);

    always_comb begin
        unique case (rate_i)
            RATE_8K:  tick_o = t8k_i;
            RATE_24K: tick_o = t24k_i;
            RATE_1K:  tick_o = t1k_i;
            default:  tick_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/tone_resonator.sv
module tone_resonator #(
    parameter int W    = 16,
    parameter int FRAC = 14
) (
    input  logic signed [W-1:0] coef_i,
    input  logic signed [W-1:0] y1_i,
    input  logic signed [W-1:0] y2_i,
    output logic signed [W-1:0] y_o
);

    localparam int PW    = 2 * W;
    localparam int ACC_W = PW + 1;
    localparam logic signed [ACC_W-1:0] SAT_HI = {{(ACC_W-W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] SAT_LO = {{(ACC_W-W+1){1'b1}}, {(W-1){1'b0}}};

    logic signed [PW-1:0]    prod;
    logic signed [PW-1:0]    scaled;
    logic signed [ACC_W-1:0] acc;

    always_comb begin
        prod   = coef_i * y1_i;
        scaled = prod >>> FRAC;
        acc    = {scaled[PW-1], scaled} - {{(ACC_W-W){y2_i[W-1]}}, y2_i};
        if (acc > SAT_HI) begin
            y_o = {1'b0, {(W-1){1'b1}}};
        end else if (acc < SAT_LO) begin
            y_o = {1'b1, {(W-1){1'b0}}};
        end else begin
            y_o = acc[W-1:0];
        end
    end

endmodule

// File: rtl/reso_tone_gen.sv
module reso_tone_gen
    import tone_pkg::*;
#(
    parameter int W    = 16,
    parameter int FRAC = 14,
    parameter int AW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [W-1:0]  cfg_wdata,
    input  logic          tick_8k,
    input  logic          tick_24k,
    input  logic          tick_1k,
    input  logic          gen_en,
    input  logic          fsk_we,
    input  logic          fsk_bit,
    output logic [W-1:0]  smp_out,
    output logic          smp_valid
);

    localparam int NREG = REG_COUNT;

    logic [NREG-1:0][W-1:0] cfg;
    gen_st_e                state_q, state_d;
    rate_e                  rate_q, rate_d;
    logic                   sel_tick;
    logic                   fsk_req_q;
    logic signed [W-1:0]    y1_q, y1_d, y2_q, y2_d;
    logic signed [W-1:0]    op_coef, op_y1, op_y2, y_next;
    logic [W-1:0]           out_d;
    logic                   vld_d;
    logic                   key_on, ring_on;

    tone_cfg_regs #(.W(W), .AW(AW), .NREG(NREG)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (cfg_we),
        .addr_i (cfg_addr),
        .data_i (cfg_wdata),
        .regs_o (cfg)
    );

    tone_rate_sel u_rate (
        .rate_i (rate_q),
        .t8k_i  (tick_8k),
        .t24k_i (tick_24k),
        .t1k_i  (tick_1k),
        .tick_o (sel_tick)
    );

    tone_resonator #(.W(W), .FRAC(FRAC)) u_res (
        .coef_i (op_coef),
        .y1_i   (op_y1),
        .y2_i   (op_y2),
        .y_o    (y_next)
    );

    assign key_on  = cfg[REG_CTRL][CTRL_KEY_BIT];
    assign ring_on = cfg[REG_CTRL][CTRL_RING_BIT];

    // requested keying bit, consumed at the next accepted strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsk_req_q <= 1'b1;
        end else if (fsk_we) begin
            fsk_req_q <= fsk_bit;
        end
    end

    // next-state and datapath decisions
    always_comb begin
        state_d = state_q;
        rate_d  = rate_q;
        y1_d    = y1_q;
        y2_d    = y2_q;
        out_d   = smp_out;
        vld_d   = 1'b0;
        op_coef = $signed(cfg[REG_TONE_COEF]);
        op_y1   = y1_q;
        op_y2   = y2_q;
        unique case (state_q)
            ST_OFF: begin
                out_d = '0;
                if (gen_en) begin
                    y2_d = '0;
                    if (key_on) begin
                        rate_d  = RATE_24K;
                        state_d = fsk_req_q ? ST_MARK : ST_SPACE;
                        y1_d    = fsk_req_q ? $signed(cfg[REG_MARK_AMP])
                                            : $signed(cfg[REG_SPACE_AMP]);
                    end else begin
                        rate_d  = ring_on ? RATE_1K : RATE_8K;
                        state_d = ST_TONE;
                        y1_d    = $signed(cfg[REG_TONE_AMP]);
                    end
                end
            end
            ST_TONE: begin
                op_coef = $signed(cfg[REG_TONE_COEF]);
            end
            ST_MARK: begin
                op_coef = $signed(cfg[REG_MARK_COEF]);
                if (sel_tick && !fsk_req_q) begin
                    state_d = ST_SPACE;
                    op_coef = $signed(cfg[REG_SPACE_COEF]);
                    op_y1   = $signed(cfg[REG_SPACE_AMP]);
                    op_y2   = '0;
                end
            end
            ST_SPACE: begin
                op_coef = $signed(cfg[REG_SPACE_COEF]);
                if (sel_tick && fsk_req_q) begin
                    state_d = ST_MARK;
                    op_coef = $signed(cfg[REG_MARK_COEF]);
                    op_y1   = $signed(cfg[REG_MARK_AMP]);
                    op_y2   = '0;
                end
            end
            default: state_d = ST_OFF;
        endcase

        if (state_q != ST_OFF) begin
            if (!gen_en) begin
                state_d = ST_OFF;
                y1_d    = '0;
                y2_d    = '0;
                out_d   = '0;
            end else if (sel_tick) begin
                y2_d  = op_y1;
                y1_d  = y_next;
                out_d = y_next;
                vld_d = 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            rate_q  <= RATE_8K;
        end else begin
            state_q <= state_d;
            rate_q  <= rate_d;
        end
    end

    // resonator history and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y1_q      <= '0;
            y2_q      <= '0;
            smp_out   <= '0;
            smp_valid <= 1'b0;
        end else begin
            y1_q      <= y1_d;
            y2_q      <= y2_d;
            smp_out   <= out_d;
            smp_valid <= vld_d;
        end
    end

    a_r6_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> (smp_out == '0 && !smp_valid));

    a_r3_valid_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_tick |=> !smp_valid);

    a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && !sel_tick) |=> $stable(smp_out));

    a_r9_key_rate: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_MARK || state_q == ST_SPACE) && sel_tick) |-> tick_24k);

    a_r11_mark_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MARK && fsk_req_q && gen_en) |=> (state_q == ST_MARK));

    a_r7_tone_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TONE && rate_q == RATE_8K && sel_tick) |-> tick_8k);

endmodule

// File: tb/reso_tone_gen_tb_top.sv
module reso_tone_gen_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        tick_8k = 1'b0, tick_24k = 1'b0, tick_1k = 1'b0;
    logic        gen_en = 1'b0;
    logic        fsk_we = 1'b0, fsk_bit = 1'b0;
    logic [15:0] smp_out;
    logic        smp_valid;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    // bench reference state
    int cfg_m [7];
    int m_st = 0;      // 0 off, 1 tone, 2 mark, 3 space
    int m_rate = 0;    // 0 8k, 1 24k, 2 1k
    int m_y1 = 0, m_y2 = 0;
    int m_fsk = 1;
    int last_exp = 0;
    int exp_q [$];
    string tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    reso_tone_gen dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tick_8k(tick_8k), .tick_24k(tick_24k),
        .tick_1k(tick_1k), .gen_en(gen_en), .fsk_we(fsk_we), .fsk_bit(fsk_bit),
        .smp_out(smp_out), .smp_valid(smp_valid)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int mstep(int c, int a, int b);
        longint p;
        p = longint'(c) * longint'(a);
        p = p >>> 14;
        p = p - longint'(b);
        if (p > 32767) p = 32767;
        if (p < -32768) p = -32768;
        return int'(p);
    endfunction

    task automatic wr(int addr, int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_wdata = 16'(val);
        cfg_m[addr] = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic fsk(int b);
        @(negedge clk);
        fsk_we = 1'b1; fsk_bit = b[0];
        @(negedge clk);
        fsk_we = 1'b0;
        m_fsk = b;
    endtask

    task automatic gen_on();
        @(negedge clk);
        gen_en = 1'b1;
        m_y2 = 0;
        if ((cfg_m[0] & 1) != 0) begin
            m_rate = 1;
            m_st = (m_fsk != 0) ? 2 : 3;
            m_y1 = (m_fsk != 0) ? cfg_m[4] : cfg_m[6];
        end else begin
            m_rate = ((cfg_m[0] & 2) != 0) ? 2 : 0;
            m_st = 1;
            m_y1 = cfg_m[2];
        end
        @(negedge clk);
    endtask

    task automatic gen_off();
        @(negedge clk);
        gen_en = 1'b0;
        m_st = 0;
        @(negedge clk);
        chk(smp_out == 16'd0, "R6 output zero after disable", int'($signed(smp_out)), 0);
        chk(smp_valid == 1'b0, "R6 no valid after disable", int'(smp_valid), 0);
    endtask

    // which: 0 = 8k, 1 = 24k, 2 = 1k
    task automatic tick(int which, string tag);
        bit expect_smp;
        int c;
        @(negedge clk);
        tick_8k = (which == 0); tick_24k = (which == 1); tick_1k = (which == 2);
        expect_smp = (m_st != 0) && (which == m_rate);
        if (expect_smp) begin
            if (m_st == 1) begin
                c = cfg_m[1];
            end else begin
                if ((m_fsk != 0) != (m_st == 2)) begin
                    m_st = (m_fsk != 0) ? 2 : 3;
                    m_y1 = (m_st == 2) ? cfg_m[4] : cfg_m[6];
                    m_y2 = 0;
                end
                c = (m_st == 2) ? cfg_m[3] : cfg_m[5];
            end
            last_exp = mstep(c, m_y1, m_y2);
            m_y2 = m_y1;
            m_y1 = last_exp;
            exp_q.push_back(last_exp);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        tick_8k = 1'b0; tick_24k = 1'b0; tick_1k = 1'b0;
        if (!expect_smp)
            chk(smp_valid == 1'b0, {tag, " ignored strobe"}, int'(smp_valid), 0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && smp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected sample", int'($signed(smp_out)), 0);
            end else begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(int'($signed(smp_out)) == e, t, int'($signed(smp_out)), e);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 7; i++) cfg_m[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(smp_out == 16'd0, "R1 reset output", int'($signed(smp_out)), 0);
        chk(smp_valid == 1'b0, "R1 reset valid", int'(smp_valid), 0);

        // R2 register map programming
        wr(0, 0);
        wr(1, 23170); wr(2, 8000);
        wr(3, 31164); wr(4, 10000);
        wr(5, 27481); wr(6, 9000);

        // tone at 8 kHz
        gen_on();
        tick(0, "R5 first tone sample");
        for (int i = 0; i < 9; i++) tick(0, "R3 tone step");
        tick(1, "R7 24k in tone");
        tick(2, "R7 1k in tone");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(int'($signed(smp_out)) == last_exp, "R13 hold", int'($signed(smp_out)), last_exp);
        end

        // R12: control rewrite while running
        wr(0, 2);
        tick(0, "R12 rate kept");
        tick(0, "R12 rate kept");
        tick(2, "R12 new rate not taken");
        gen_off();
        tick(0, "R6 strobe while off");
        chk(smp_out == 16'd0, "R6 still zero", int'($signed(smp_out)), 0);

        // ringing rate
        gen_on();
        for (int i = 0; i < 6; i++) tick(2, "R8 ring step");
        tick(0, "R8 8k in ring");
        gen_off();

        // saturation
        wr(0, 0); wr(1, 32767); wr(2, 30000);
        gen_on();
        for (int i = 0; i < 4; i++) tick(0, "R4 positive clamp");
        gen_off();
        wr(1, -32768);
        gen_on();
        for (int i = 0; i < 3; i++) tick(0, "R4 negative clamp");
        gen_off();

        // keying
        wr(0, 1);
        fsk(1);
        gen_on();
        for (int i = 0; i < 5; i++) tick(1, "R9 R2 mark step");
        tick(0, "R9 8k in keying");
        fsk(0);
        tick(1, "R10 swap to space");
        for (int i = 0; i < 3; i++) tick(1, "R10 space step");
        fsk(0);
        tick(1, "R11 same bit");
        tick(1, "R11 same bit");
        fsk(1);
        tick(1, "R10 swap to mark");
        for (int i = 0; i < 2; i++) tick(1, "R10 mark step");
        gen_off();
        fsk(0);
        gen_on();
        for (int i = 0; i < 3; i++) tick(1, "R9 start in space");
        gen_off();

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all samples issued", exp_q.size(), 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule